// File: doc/BRIEF.md
# Configurable PLD Output Cell

This block is the output stage of a programmable logic cell slice. Each lane takes a sum-of-products term from the logic array, along with its own clock term, asynchronous clear term, asynchronous set term and drive-enable term. One shared global clock pin serves every lane. A small static configuration register, shared by all lanes, sets four things: whether the lane's single storage element acts as a pass-through, a D flop, a T flop or a level-sensitive latch; whether the result is inverted; which clock source is used; and whether that clock is inverted.

Every lane drives a pad value with a separate drive-enable and a feedback value for the routing fabric. The feedback is present at all times. Two test controls act on all lanes together. The first loads the storage element from the pad input value. The second forces the pad drivers on so that a buried register can be read.

The whole block runs from one system clock `clk`. The selected clock source is sampled on `clk`, and a rising transition of the selected (possibly inverted) signal counts as an active edge. The clear and set terms take effect on the outputs in the same cycle they are raised, without waiting for any active edge, and they are also stored.

Top module: `pld_out_cell`

## Requirements
- R1: A write (`cfg_we`=1) loads `cfg_wdata` into the configuration register at the next `clk` edge. The field layout is: bits[1:0] mode (00 pass-through, 01 D flop, 10 T flop, 11 latch), bit2 output invert, bit3 clock source (0 global pin, 1 lane clock term), bit4 clock invert. Reset clears all bits, which selects pass-through, no inversion and the global pin in true form.
- R2: The selected clock is the global pin or the lane clock term, inverted when bit4 is set. An active edge is a 0-to-1 change of that selected signal between two `clk` samples. The stored value changes at the `clk` edge that samples the change. Transitions in the opposite direction do nothing.
- R3: In D mode, an active edge loads the sum-of-products value. With no active edge, the stored value holds.
- R4: In T mode, an active edge with input 1 inverts the stored value. An active edge with input 0, or no active edge, leaves it unchanged.
- R5: In latch mode, while the selected signal is 0 the output follows the input in the same cycle and the input is stored. While the selected signal is 1 the stored value holds. With bit4 set, the latch is therefore open while the pin is high.
- R6: In pass-through mode the pad value follows the sum-of-products input in the same cycle.
- R7: When bit2 is set, the pad value and the feedback value are the inverse of the lane's internal result, in every mode.
- R8: A raised clear term forces the lane's result to 0 in the same cycle. A raised set term alone forces it to 1. With both raised the result is 0. The forced value is stored, and no active edge is needed.
- R9: The feedback output carries the same polarity-adjusted result as the pad value, whatever the drive-enable is.
- R10: The pad drive-enable of a lane is high exactly when its enable term is high or observe is active. A low drive-enable releases the pad to high impedance.
- R11: After reset every storage element holds 0. In a registered mode the pad value then equals the output-invert bit.
- R12: With preload active, the next `clk` edge loads the pad input value into the storage element. Clear and set take priority over preload.
- R13: With observe active, every pad drive-enable is high and the pad shows the stored value. A pass-through lane then acts as a D flop whose input is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration write data |
| gclk_pin | input | 1 | Global clock pin level |
| sop_in | input | WIDTH | Sum-of-products input per lane |
| clk_pt | input | WIDTH | Lane clock term |
| ar_pt | input | WIDTH | Lane asynchronous clear term |
| ap_pt | input | WIDTH | Lane asynchronous set term |
| oe_pt | input | WIDTH | Lane drive-enable term |
| pad_in | input | WIDTH | Pad level seen from outside, used by preload |
| preload_en | input | 1 | Load storage from pad level |
| observe_en | input | 1 | Force drivers on and show stored value |
| pad_out | output | WIDTH | Pad drive value |
| pad_oe | output | WIDTH | Pad drive-enable (0 means high impedance) |
| fb_out | output | WIDTH | Feedback to the routing fabric |

## Verification
The bench builds the block with WIDTH=2 and gives each lane different clear, set, preload and clock-term values under one shared configuration. This exposes any leak between lanes that share a configuration. It also shows that observe and preload act on every lane together while clear and set stay per-lane. A model loop visits all three storage modes under all four clock selections, driven by a pseudo-random pin, term and data pattern. This reaches both edge directions and both latch levels in every combination.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  typedef enum logic [1:0] {
    MODE_COMB  = 2'b00,
    MODE_DREG  = 2'b01,
    MODE_TREG  = 2'b10,
    MODE_LATCH = 2'b11
  } mc_mode_e;

  typedef struct packed {
    logic     clk_inv;
    logic     clk_from_pt;
    logic     out_inv;
    mc_mode_e mode;
  } mc_cfg_t;

  localparam int CFG_W = $bits(mc_cfg_t);

  // Next stored value from the clocked function alone (no clear/set/preload).
  function automatic logic mc_next(input mc_mode_e m, input logic q,
                                   input logic d, input logic edge_hit,
                                   input logic gate_open);
    logic r;
    case (m)
      MODE_DREG:  r = edge_hit ? d : q;
      MODE_TREG:  r = edge_hit ? (q ^ d) : q;
      MODE_LATCH: r = gate_open ? d : q;
      default:    r = q;
    endcase
    return r;
  endfunction

  // Observe turns a pass-through cell into a D register.
  function automatic mc_mode_e mc_eff_mode(input mc_mode_e m, input logic observe);
    return (observe && m == MODE_COMB) ? MODE_DREG : m;
  endfunction

endpackage

// File: rtl/mcell_cfg_reg.sv
module mcell_cfg_reg
  import mcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output mc_cfg_t          cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= '0;
    else if (we) cfg <= mc_cfg_t'(wdata);
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg == $past(wdata))); // R1

endmodule

// File: rtl/mcell_clk_sel.sv
module mcell_clk_sel #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gclk_pin,
  input  logic [WIDTH-1:0] clk_pt,
  input  logic             from_pt,
  input  logic             invert,
  output logic [WIDTH-1:0] edge_hit,
  output logic [WIDTH-1:0] gate_open
);

  logic [WIDTH-1:0] sel_lvl;
  logic [WIDTH-1:0] sel_prev;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign sel_lvl[i]   = (from_pt ? clk_pt[i] : gclk_pin) ^ invert;
    assign edge_hit[i]  = sel_lvl[i] & ~sel_prev[i];
    assign gate_open[i] = ~sel_lvl[i];

    // Prev starts high so that no edge is seen in the first cycle after reset.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_prev[i] <= 1'b1;
      else        sel_prev[i] <= sel_lvl[i];
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit[i] |=> !edge_hit[i]); // R2
  end

endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mc_mode_e         mode,
  input  logic [WIDTH-1:0] d,
  input  logic [WIDTH-1:0] edge_hit,
  input  logic [WIDTH-1:0] gate_open,
  input  logic [WIDTH-1:0] ar,
  input  logic [WIDTH-1:0] ap,
  input  logic             preload,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] q_vis
);

  logic [WIDTH-1:0] q_reg;
  logic [WIDTH-1:0] q_nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    always_comb begin
      if (ar[i])        q_nxt[i] = 1'b0;
      else if (ap[i])   q_nxt[i] = 1'b1;
      else if (preload) q_nxt[i] = pad_in[i];
      else              q_nxt[i] = mc_next(mode, q_reg[i], d[i], edge_hit[i], gate_open[i]);
    end

    always_comb begin
      if (ar[i])                                   q_vis[i] = 1'b0;
      else if (ap[i])                              q_vis[i] = 1'b1;
      else if (mode == MODE_LATCH && gate_open[i]) q_vis[i] = d[i];
      else                                         q_vis[i] = q_reg[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_reg[i] <= 1'b0;
      else        q_reg[i] <= q_nxt[i];
    end

    AST_CLEAR_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      ar[i] |=> (q_reg[i] == 1'b0)); // R8
    AST_SET_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ap[i] && !ar[i]) |=> (q_reg[i] == 1'b1)); // R8
    AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (preload && !ar[i] && !ap[i]) |=> (q_reg[i] == $past(pad_in[i]))); // R12
    AST_FLOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == MODE_DREG || mode == MODE_TREG) && !edge_hit[i] &&
       !ar[i] && !ap[i] && !preload) |=> $stable(q_reg[i])); // R3
    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_TREG && edge_hit[i] && d[i] && !ar[i] && !ap[i] && !preload)
      |=> (q_reg[i] != $past(q_reg[i]))); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_LATCH && !gate_open[i] && !ar[i] && !ap[i] && !preload)
      |=> $stable(q_reg[i])); // R5
  end

endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import mcell_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             gclk_pin,
  input  logic [WIDTH-1:0] sop_in,
  input  logic [WIDTH-1:0] clk_pt,
  input  logic [WIDTH-1:0] ar_pt,
  input  logic [WIDTH-1:0] ap_pt,
  input  logic [WIDTH-1:0] oe_pt,
  input  logic [WIDTH-1:0] pad_in,
  input  logic             preload_en,
  input  logic             observe_en,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] fb_out
);

  mc_cfg_t          cfg;
  mc_mode_e         eff_mode;
  logic [WIDTH-1:0] st_d;
  logic [WIDTH-1:0] edge_hit;
  logic [WIDTH-1:0] gate_open;
  logic [WIDTH-1:0] q_vis;
  logic [WIDTH-1:0] core;
  logic             obs_zero;

  assign eff_mode = mc_eff_mode(cfg.mode, observe_en);
  assign obs_zero = observe_en && (cfg.mode == MODE_COMB);

  mcell_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  mcell_clk_sel #(.WIDTH(WIDTH)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gclk_pin  (gclk_pin),
    .clk_pt    (clk_pt),
    .from_pt   (cfg.clk_from_pt),
    .invert    (cfg.clk_inv),
    .edge_hit  (edge_hit),
    .gate_open (gate_open)
  );

  mcell_store #(.WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (eff_mode),
    .d         (st_d),
    .edge_hit  (edge_hit),
    .gate_open (gate_open),
    .ar        (ar_pt),
    .ap        (ap_pt),
    .preload   (preload_en),
    .pad_in    (pad_in),
    .q_vis     (q_vis)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign st_d[i]    = obs_zero ? 1'b0 : sop_in[i];
    assign core[i]    = (eff_mode == MODE_COMB) ? sop_in[i] : q_vis[i];
    assign pad_out[i] = core[i] ^ cfg.out_inv;
    assign fb_out[i]  = core[i] ^ cfg.out_inv;
    assign pad_oe[i]  = oe_pt[i] | observe_en;
  end

endmodule

// File: tb/test_pld_out_cell.sv
module test_pld_out_cell;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       gclk_pin = 1'b0;
  logic [1:0] sop_in = '0, clk_pt = '0, ar_pt = '0, ap_pt = '0, oe_pt = '0, pad_in = '0;
  logic       preload_en = 1'b0, observe_en = 1'b0;
  logic [1:0] pad_out, pad_oe, fb_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pld_out_cell #(.WIDTH(2)) i_pld_out_cell (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .gclk_pin(gclk_pin), .sop_in(sop_in), .clk_pt(clk_pt), .ar_pt(ar_pt),
    .ap_pt(ap_pt), .oe_pt(oe_pt), .pad_in(pad_in), .preload_en(preload_en),
    .observe_en(observe_en), .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
  );

  task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] mode, input logic inv,
                           input logic src, input logic cinv);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {cinv, src, inv, mode};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5 check("R11 cleared, pass-through", pad_out, 2'b00);
    check("R10 drivers off", pad_oe, 2'b00);
    @(negedge clk);
    sop_in = 2'b11;
    #5 check("R1 reset config is pass-through", pad_out, 2'b11);
    sop_in = 2'b00;
    write_cfg(2'b01, 1'b1, 1'b0, 1'b0);
    #5 check("R11 stored zero inverted", pad_out, 2'b11);
  endtask

  task automatic t_comb();
    write_cfg(2'b00, 1'b0, 1'b0, 1'b0);
    sop_in = 2'b01;
    #5 check("R6 follows input", pad_out, 2'b01);
    @(negedge clk);
    sop_in = 2'b10;
    #5 check("R6 follows input", pad_out, 2'b10);
    write_cfg(2'b00, 1'b1, 1'b0, 1'b0);
    #5 check("R7 inverted pad", pad_out, 2'b01);
    check("R9 feedback with drivers off", fb_out, 2'b01);
    check("R10 high impedance", pad_oe, 2'b00);
  endtask

  task automatic t_dreg();
    write_cfg(2'b01, 1'b0, 1'b0, 1'b0);
    ar_pt = 2'b11;
    settle();
    @(negedge clk);
    ar_pt = 2'b00; gclk_pin = 1'b0; sop_in = 2'b01;
    settle();
    check("R3 no edge holds", pad_out, 2'b00);
    @(negedge clk);
    gclk_pin = 1'b1;
    settle();
    check("R3 capture on rising pin", pad_out, 2'b01);
    @(negedge clk);
    sop_in = 2'b10;
    settle();
    check("R3 hold while pin high", pad_out, 2'b01);
    @(negedge clk);
    gclk_pin = 1'b0;
    settle();
    check("R2 falling pin ignored", pad_out, 2'b01);
    @(negedge clk);
    gclk_pin = 1'b1;
    settle();
    check("R3 second capture", pad_out, 2'b10);
    write_cfg(2'b01, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    sop_in = 2'b11; gclk_pin = 1'b0;
    settle();
    check("R2 inverted pin captures on fall", pad_out, 2'b11);
  endtask

  task automatic t_treg();
    write_cfg(2'b10, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    ar_pt = 2'b11; clk_pt = 2'b00; sop_in = 2'b00;
    settle();
    @(negedge clk);
    ar_pt = 2'b00; sop_in = 2'b01; clk_pt = 2'b11;
    settle();
    check("R4 toggle lane0 only", pad_out, 2'b01);
    @(negedge clk);
    clk_pt = 2'b00;
    settle();
    check("R4 hold without edge", pad_out, 2'b01);
    @(negedge clk);
    clk_pt = 2'b11;
    settle();
    check("R4 toggle back", pad_out, 2'b00);
  endtask

  task automatic t_latch();
    write_cfg(2'b11, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    clk_pt = 2'b00; gclk_pin = 1'b0; sop_in = 2'b01;
    #5 check("R5 open follows", pad_out, 2'b01);
    @(negedge clk);
    sop_in = 2'b10;
    #5 check("R5 open follows", pad_out, 2'b10);
    @(negedge clk);
    gclk_pin = 1'b1;
    #5 check("R5 close keeps value", pad_out, 2'b10);
    @(negedge clk);
    sop_in = 2'b01;
    #5 check("R5 closed holds", pad_out, 2'b10);
    write_cfg(2'b11, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    sop_in = 2'b11;
    #5 check("R5 inverted open while pin high", pad_out, 2'b11);
  endtask

  task automatic t_arap();
    write_cfg(2'b01, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    gclk_pin = 1'b0; ar_pt = 2'b11;
    settle();
    @(negedge clk);
    ar_pt = 2'b00; ap_pt = 2'b01;
    #5 check("R8 set without clock", pad_out, 2'b01);
    @(negedge clk);
    ar_pt = 2'b01;
    #5 check("R8 clear wins over set", pad_out, 2'b00);
    @(negedge clk);
    ar_pt = 2'b00; ap_pt = 2'b00;
    #5 check("R8 clear stored", pad_out, 2'b00);
    @(negedge clk);
    ap_pt = 2'b10;
    @(negedge clk);
    ap_pt = 2'b00;
    #5 check("R8 set stored per lane", pad_out, 2'b10);
  endtask

  task automatic t_test_modes();
    write_cfg(2'b00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    sop_in = 2'b00; oe_pt = 2'b00; gclk_pin = 1'b0;
    preload_en = 1'b1; pad_in = 2'b01;
    @(negedge clk);
    preload_en = 1'b0;
    #5 check("R10 drivers off", pad_oe, 2'b00);
    @(negedge clk);
    observe_en = 1'b1;
    #5 check("R13 observe forces drivers", pad_oe, 2'b11);
    check("R12 preload value visible", pad_out, 2'b01);
    @(negedge clk);
    sop_in = 2'b11; gclk_pin = 1'b1;
    settle();
    check("R13 pass-through input treated as zero", pad_out, 2'b00);
    @(negedge clk);
    observe_en = 1'b0; gclk_pin = 1'b0; oe_pt = 2'b10;
    #5 check("R10 per-lane enable", pad_oe, 2'b10);
    check("R9 feedback", fb_out, 2'b11);
    @(negedge clk);
    preload_en = 1'b1; pad_in = 2'b11; ar_pt = 2'b01;
    @(negedge clk);
    preload_en = 1'b0; ar_pt = 2'b00; observe_en = 1'b1;
    #5 check("R12 clear beats preload", pad_out, 2'b10);
    @(negedge clk);
    observe_en = 1'b0; oe_pt = 2'b00;
  endtask

  task automatic t_matrix();
    logic [7:0] lf = 8'hA5;
    for (int m = 1; m <= 3; m++) begin
      for (int s = 0; s <= 1; s++) begin
        for (int p = 0; p <= 1; p++) begin
          logic q, prv, sel, opn, e, expv;
          write_cfg(m[1:0], 1'b0, s[0], p[0]);
          @(negedge clk);
          ar_pt = 2'b01; gclk_pin = 1'b0; clk_pt = 2'b00; sop_in = 2'b00;
          @(posedge clk);
          q = 1'b0; prv = p[0];
          for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            ar_pt = 2'b00;
            gclk_pin = lf[0]; clk_pt = {1'b0, lf[1]}; sop_in = {1'b0, lf[2]};
            @(posedge clk);
            sel = (s[0] ? lf[1] : lf[0]) ^ p[0];
            opn = !sel;
            e = sel && !prv;
            prv = sel;
            if (m == 1 && e) q = lf[2];
            if (m == 2 && e && lf[2]) q = !q;
            if (m == 3 && opn) q = lf[2];
            #2;
            expv = (m == 3 && opn) ? lf[2] : q;
            check($sformatf("R2 R3 R4 R5 model mode%0d src%0d inv%0d", m, s, p),
                  {1'b0, pad_out[0]}, {1'b0, expv});
          end
        end
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_comb();
    t_dreg();
    t_treg();
    t_latch();
    t_arap();
    t_test_modes();
    t_matrix();
    finish_run();
  end

endmodule